// File: doc/BRIEF.md
# Four-Level Hardware Page Walker

This block resolves a 48-bit virtual address to a physical frame after a translation-cache miss. It walks a four-level radix tree of 512-entry tables. It starts at the table whose frame number is supplied on `root_ppn` and takes one 9-bit slice of the virtual address per level. It issues one 64-bit read per level on a plain request/response memory port. Every table address it forms is physical, so its own reads are never translated.

A walk ends in one of two ways. It can return a translation, which gives the 4 KiB frame number for the requested address, the page size, the combined permissions and an aligned virtual page number ready to be written into the translation cache. It can instead raise a fault that reports the offending virtual address. An entry with its large-page bit set at the second or third level ends the walk early with a 1 GiB or 2 MiB page. An entry whose present bit is clear at any level aborts the walk.

Top module: `pt_walk_engine`

## Requirements
- R1: Out of reset the block is idle: `busy`, `done`, `fault` and `mem_req_valid` are all low.
- R2: A `req_valid` seen while idle captures `req_va` and `root_ppn`, raises `busy` on the next cycle and starts the walk at the table whose frame number is `root_ppn`.
- R3: At each level the read address is table frame × 4096 + index × 8. The index comes from VA[47:39], VA[38:30], VA[29:21] and VA[20:12] in walk order. Entry bits 51:12 give the frame number of the next table.
- R4: An entry with bit 0 (present) clear pulses `fault` for one cycle with `fault_va` equal to the captured address, and no further read is issued for that walk.
- R5: A present entry at the fourth level completes the walk after four reads, with `res_ppn` = entry[51:12] and `res_size` = 0 (4 KiB).
- R6: A present entry with bit 7 set at the third level completes after three reads, with `res_size` = 1 (2 MiB) and `res_ppn` = {entry[51:21], VA[20:12]}.
- R7: A present entry with bit 7 set at the second level completes after two reads, with `res_size` = 2 (1 GiB) and `res_ppn` = {entry[51:30], VA[29:12]}.
- R8: Bit 7 has no effect at the first and fourth levels: the walk continues from the first level and ends as a 4 KiB page at the fourth.
- R9: `res_write` is the AND of bit 1 over all visited entries, and `res_user` is the AND of bit 2. `res_exec` is the AND of the inverted bit 63.
- R10: With `done`, `fill_vpn` equals VA[47:12] with the page-offset bits of the returned size cleared (none for 4 KiB, 9 for 2 MiB, 18 for 1 GiB).
- R11: Each read request lasts exactly one cycle, and the next level's request waits for the response to the previous one.
- R12: `busy` stays high from the cycle after acceptance until the cycle `done` or `fault` pulses, and a `req_valid` seen while busy is ignored.
- R13: `done` and `fault` are one-cycle pulses that never coincide. They are never both issued for the same walk, and result outputs hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ppn | input | 40 | Frame number of the top-level table |
| req_valid | input | 1 | Walk request strobe |
| req_va | input | 48 | Virtual address to translate |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request, one cycle |
| mem_req_addr | output | 52 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| done | output | 1 | Translation completed (also fill strobe) |
| fault | output | 1 | Walk aborted on a not-present entry |
| fault_va | output | 48 | Virtual address of the faulted walk |
| res_ppn | output | 40 | 4 KiB frame number for the requested address |
| res_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| res_write | output | 1 | Combined write permission |
| res_user | output | 1 | Combined user permission |
| res_exec | output | 1 | Combined execute permission |
| fill_vpn | output | 36 | Size-aligned virtual page number for the cache fill |

## Verification
The bench builds sparse tables in which only the correctly indexed entries exist. A design that takes a wrong address slice or scales the index wrongly reads an empty slot and faults where a translation is expected. It also counts reads per walk, so a walker that fails to stop at a 2 MiB or 1 GiB entry, or that keeps reading after a not-present entry, shows up as a wrong read count. Other cases check that a large-page bit at the top or bottom level is ignored rather than ending the walk, and that a restriction set only at the top level still reaches the combined permissions. A request pulsed in the middle of a walk must change neither the result nor the number of completions; a design that restarted would produce a second, unexpected result.

// File: rtl/pt_walk_engine.sv
module pt_walk_engine #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int PTE_W  = 64,
  parameter int IDX_W  = 9,
  parameter int PG_SH  = 12,
  parameter int LEVELS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PA_W-PG_SH-1:0]    root_ppn,
  input  logic                     req_valid,
  input  logic [VA_W-1:0]          req_va,
  output logic                     busy,
  output logic                     mem_req_valid,
  output logic [PA_W-1:0]          mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [PTE_W-1:0]         mem_rsp_data,
  output logic                     done,
  output logic                     fault,
  output logic [VA_W-1:0]          fault_va,
  output logic [PA_W-PG_SH-1:0]    res_ppn,
  output logic [1:0]               res_size,
  output logic                     res_write,
  output logic                     res_user,
  output logic                     res_exec,
  output logic [VA_W-PG_SH-1:0]    fill_vpn
);
  localparam int PPN_W = PA_W - PG_SH;
  localparam int VPN_W = VA_W - PG_SH;
  localparam int LVL_W = $clog2(LEVELS);
  localparam int B_PRESENT = 0;
  localparam int B_WRITE   = 1;
  localparam int B_USER    = 2;
  localparam int B_LARGE   = 7;
  localparam int B_NOEXEC  = PTE_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t             st;
  logic [LVL_W-1:0]   lvl;
  logic [VA_W-1:0]    va_q;
  logic [PPN_W-1:0]   base_q;
  logic               wr_acc, us_acc, ex_acc;

  function automatic logic [IDX_W-1:0] slice_of(input logic [VA_W-1:0] va, input logic [LVL_W-1:0] l);
    int sh;
    sh = PG_SH + IDX_W * (LEVELS - 1 - int'(l));
    return va[sh +: IDX_W];
  endfunction

  function automatic logic [PPN_W-1:0] low_mask(input logic [LVL_W-1:0] l);
    logic [PPN_W-1:0] m;
    for (int i = 0; i < PPN_W; i++)
      m[i] = (i < IDX_W * (LEVELS - 1 - int'(l)));
    return m;
  endfunction

  logic [IDX_W-1:0] idx;
  logic [PPN_W-1:0] ent_ppn, msk, vpn_ext, leaf_ppn;
  logic             present, large_ok, leaf;
  logic             wr_n, us_n, ex_n;

  assign idx     = slice_of(va_q, lvl);
  assign ent_ppn = mem_rsp_data[PA_W-1:PG_SH];
  assign present = mem_rsp_data[B_PRESENT];
  assign large_ok = mem_rsp_data[B_LARGE] && lvl != '0 && lvl != LVL_W'(LEVELS-1);
  assign leaf    = large_ok || lvl == LVL_W'(LEVELS-1);
  assign msk     = low_mask(lvl);
  assign vpn_ext = PPN_W'(va_q[VA_W-1:PG_SH]);
  assign leaf_ppn = (ent_ppn & ~msk) | (vpn_ext & msk);
  assign wr_n    = wr_acc & mem_rsp_data[B_WRITE];
  assign us_n    = us_acc & mem_rsp_data[B_USER];
  assign ex_n    = ex_acc & ~mem_rsp_data[B_NOEXEC];

  assign busy          = st != S_IDLE;
  assign mem_req_valid = st == S_ISSUE;
  assign mem_req_addr  = {base_q, {PG_SH{1'b0}}} | PA_W'({idx, 3'b000});

  logic unused_pte_bits;
  assign unused_pte_bits = ^{mem_rsp_data[PTE_W-2:PA_W], mem_rsp_data[PG_SH-1:B_LARGE+1],
                             mem_rsp_data[B_LARGE-1:B_USER+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lvl       <= '0;
      va_q      <= '0;
      base_q    <= '0;
      wr_acc    <= 1'b1;
      us_acc    <= 1'b1;
      ex_acc    <= 1'b1;
      done      <= 1'b0;
      fault     <= 1'b0;
      fault_va  <= '0;
      res_ppn   <= '0;
      res_size  <= '0;
      res_write <= 1'b0;
      res_user  <= 1'b0;
      res_exec  <= 1'b0;
      fill_vpn  <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          base_q <= root_ppn;
          lvl    <= '0;
          wr_acc <= 1'b1;
          us_acc <= 1'b1;
          ex_acc <= 1'b1;
          st     <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!present) begin
            fault    <= 1'b1;
            fault_va <= va_q;
            st       <= S_IDLE;
          end else if (leaf) begin
            done      <= 1'b1;
            res_ppn   <= leaf_ppn;
            res_size  <= 2'(LEVELS - 1 - int'(lvl));
            res_write <= wr_n;
            res_user  <= us_n;
            res_exec  <= ex_n;
            fill_vpn  <= va_q[VA_W-1:PG_SH] & ~msk[VPN_W-1:0];
            st        <= S_IDLE;
          end else begin
            base_q <= ent_ppn;
            lvl    <= lvl + LVL_W'(1);
            wr_acc <= wr_n;
            us_acc <= us_n;
            ex_acc <= ex_n;
            st     <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walk_engine_checks.sv
module pt_walk_engine_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        mem_req_valid,
  input logic [51:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        done,
  input logic        fault,
  input logic [1:0]  res_size
);
  p_idle_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  p_entry_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

  p_one_cycle_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  p_no_req_on_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);

  p_end_of_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || fault));

  p_pulse_after_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> (!busy && $past(busy)));

  p_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_size_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_size != 2'd3);
endmodule

bind pt_walk_engine pt_walk_engine_checks u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .done(done), .fault(fault), .res_size(res_size)
);

// File: tb/pt_walk_engine_test.sv
`timescale 1ns/100ps
module pt_walk_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] root_ppn = 40'h100;
  logic        req_valid = 1'b0;
  logic [47:0] req_va = '0;
  logic        busy, mem_req_valid, done, fault;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic [47:0] fault_va;
  logic [39:0] res_ppn;
  logic [1:0]  res_size;
  logic        res_write, res_user, res_exec;
  logic [35:0] fill_vpn;

  always #2.5 clk = ~clk;

  pt_walk_engine uut (
    .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn), .req_valid(req_valid), .req_va(req_va),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
    .fault_va(fault_va), .res_ppn(res_ppn), .res_size(res_size), .res_write(res_write),
    .res_user(res_user), .res_exec(res_exec), .fill_vpn(fill_vpn)
  );

  typedef struct {
    string       req;
    logic        is_fault;
    logic [47:0] va;
    logic [39:0] ppn;
    logic [1:0]  size;
    logic        w, u, x;
    int          reads;
  } exp_t;

  exp_t exp_q[$];
  logic [63:0] mem [logic [51:0]];
  int n_chk = 0, n_bad = 0, reads_seen = 0;

  localparam logic [63:0] F_P = 64'h1, F_W = 64'h2, F_U = 64'h4, F_L = 64'h80, F_NX = 64'h1 << 63;

  function automatic logic [63:0] pte(input logic [39:0] ppn, input logic [63:0] fl);
    return {12'b0, ppn, 12'b0} | fl;
  endfunction
  function automatic logic [51:0] ea(input logic [39:0] ppn, input logic [8:0] ix);
    return {ppn, 12'b0} + {40'b0, ix, 3'b0};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // memory responder
  logic        pend = 1'b0;
  logic [51:0] paddr;
  int          dly;
  always @(negedge clk) begin
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    if (mem_req_valid) begin
      pend = 1'b1; paddr = mem_req_addr; dly = 2; reads_seen++;
    end else if (pend) begin
      if (dly == 0) begin
        mem_rsp_data  = mem.exists(paddr) ? mem[paddr] : 64'h0;
        mem_rsp_valid = 1'b1;
        pend = 1'b0;
      end else dly--;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && (done || fault)) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R12: unexpected completion actual done=%0b fault=%0b expected none", done, fault);
      end else begin
        exp_t e;
        logic [35:0] fv;
        e = exp_q.pop_front();
        check({e.req, " R13 outcome"}, {62'b0, done, fault}, {62'b0, !e.is_fault, e.is_fault});
        check("R3 read count", 64'(reads_seen), 64'(e.reads));
        if (e.is_fault) check("R4 fault_va", 64'(fault_va), 64'(e.va));
        else begin
          check({e.req, " ppn"}, 64'(res_ppn), 64'(e.ppn));
          check({e.req, " size"}, 64'(res_size), 64'(e.size));
          check("R9 perms", {61'b0, res_write, res_user, res_exec}, {61'b0, e.w, e.u, e.x});
          fv = e.va[47:12];
          if (e.size == 2'd1) fv[8:0] = '0;
          if (e.size == 2'd2) fv[17:0] = '0;
          check("R10 fill_vpn", 64'(fill_vpn), 64'(fv));
        end
      end
      reads_seen = 0;
    end
  end

  task automatic push(input string tag, input logic flt, input logic [47:0] va, input logic [39:0] ppn,
                      input logic [1:0] sz, input logic w, input logic u, input logic x, input int rd);
    exp_t e;
    e.req = tag; e.is_fault = flt; e.va = va; e.ppn = ppn; e.size = sz;
    e.w = w; e.u = u; e.x = x; e.reads = rd;
    exp_q.push_back(e);
  endtask

  task automatic walk(input logic [47:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  logic [47:0] va1, va2, va3, va4, va5, va6, va7, va8;

  initial begin
    va1 = {9'd1, 9'd2, 9'd3, 9'd4, 12'h123};
    va2 = {9'd1, 9'd2, 9'd5, 9'd7, 12'h456};
    va3 = {9'd1, 9'd6, 9'd9, 9'd10, 12'h000};
    va4 = {9'd3, 9'd0, 9'd0, 9'd0, 12'h010};
    va5 = {9'd1, 9'd2, 9'd3, 9'd8, 12'h000};
    va6 = {9'd1, 9'd2, 9'd3, 9'd11, 12'h000};
    va7 = {9'd2, 9'd0, 9'd0, 9'd0, 12'h000};
    va8 = {9'd4, 9'd0, 9'd0, 9'd0, 12'hfff};
    mem[ea(40'h100, 9'd1)]  = pte(40'h101, F_P | F_W | F_U);
    mem[ea(40'h101, 9'd2)]  = pte(40'h102, F_P | F_W | F_U);
    mem[ea(40'h102, 9'd3)]  = pte(40'h103, F_P | F_W | F_U);
    mem[ea(40'h103, 9'd4)]  = pte(40'h55555, F_P | F_W | F_U);
    mem[ea(40'h102, 9'd5)]  = pte(40'hA00, F_P | F_W | F_L);
    mem[ea(40'h101, 9'd6)]  = pte(40'h40000, F_P | F_U | F_L | F_NX);
    mem[ea(40'h103, 9'd11)] = pte(40'h777, F_P | F_U | F_NX);
    mem[ea(40'h100, 9'd2)]  = pte(40'h110, F_P | F_U);
    mem[ea(40'h110, 9'd0)]  = pte(40'h111, F_P | F_W | F_U);
    mem[ea(40'h111, 9'd0)]  = pte(40'h112, F_P | F_W | F_U);
    mem[ea(40'h112, 9'd0)]  = pte(40'h999, F_P | F_W | F_U);
    mem[ea(40'h100, 9'd4)]  = pte(40'h120, F_P | F_W | F_U | F_L);
    mem[ea(40'h120, 9'd0)]  = pte(40'h121, F_P | F_W | F_U);
    mem[ea(40'h121, 9'd0)]  = pte(40'h122, F_P | F_W | F_U);
    mem[ea(40'h122, 9'd0)]  = pte(40'h333, F_P | F_W | F_U | F_L);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset idle", {60'b0, busy, done, fault, mem_req_valid}, 64'h0);

    push("R5", 0, va1, 40'h55555, 2'd0, 1, 1, 1, 4);  walk(va1);   // R2 R3 R5
    push("R6", 0, va2, 40'hA07, 2'd1, 1, 0, 1, 3);    walk(va2);
    push("R7", 0, va3, 40'h4120A, 2'd2, 0, 1, 0, 2);  walk(va3);
    push("R4", 1, va4, '0, 2'd0, 0, 0, 0, 1);         walk(va4);   // top-level not present
    push("R4", 1, va5, '0, 2'd0, 0, 0, 0, 4);         walk(va5);   // leaf not present
    push("R9", 0, va6, 40'h777, 2'd0, 0, 1, 0, 4);    walk(va6);
    push("R9", 0, va7, 40'h999, 2'd0, 0, 1, 1, 4);    walk(va7);   // top-level write restriction
    push("R8", 0, va8, 40'h333, 2'd0, 1, 1, 1, 4);    walk(va8);

    // R12: request during a walk is ignored
    push("R12", 0, va1, 40'h55555, 2'd0, 1, 1, 1, 4);
    @(negedge clk);
    req_valid = 1'b1; req_va = va1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 busy mid-walk", 64'(busy), 64'h1);
    req_valid = 1'b1; req_va = va3;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R12 no second walk", {63'b0, busy}, 64'h0);
    check("R12 queue drained", 64'(exp_q.size()), 64'h0);
    check("R13 results held", 64'(res_ppn), 64'h55555);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end
endmodule